// File: doc/BRIEF.md
# SPI Frame CRC Generator and Checker

This block keeps a cyclic redundancy check running beside a serial shift engine. Each time the engine finishes a frame, the block folds the outgoing word into a transmit accumulator and the incoming word into a separate receive accumulator. The generator polynomial can be changed by a write. Words are either 8 or 16 bits wide. The shift engine reports each finished frame with a single-cycle strobe and presents both words on that cycle.

Software asks for the check word with a one-shot request. The frame that completes next is the last data word. The slot after it carries the check word: the block raises `crc_slot`, and the engine transmits the value on `tx_crc`. When that slot's frame completes, the word received in it is compared with the receive accumulator. A mismatch sets a sticky error flag, which software clears by writing a status word with the flag's bit at 0.

A small state machine sequences this. The states are OFF (calculation disabled), IDLE (accumulating), ARMED (request taken, waiting for the last data word) and SEND (the check-word slot). Its transitions are:
- OFF to IDLE when the enable is set.
- IDLE to ARMED on a request.
- ARMED to SEND on a finished frame.
- SEND to IDLE on a finished frame.
- Any state to OFF when the enable is cleared.

Top module: `frame_crc_engine`

## Requirements
- R1: After reset, `poly_q` is 0x0007, `tx_crc`, `rx_crc` and `crc_err` are 0, and `next_pend` and `crc_slot` are low.
- R2: A cycle with `poly_wr` high loads `poly_wdata` into the polynomial, visible on `poly_q` from the next cycle.
- R3: While enabled, a `frame_done` cycle outside the check slot updates `tx_crc` on the next cycle. The word is folded in MSB first, one bit per step: feedback = accumulator top bit XOR data bit, the accumulator shifts left, and it is XORed with the polynomial when feedback is 1. With `wide_mode`=1 the whole 16-bit word and polynomial are used. With `wide_mode`=0 only bits 7:0 of the word, polynomial and accumulator are used, and bits 15:8 of the result are 0.
- R4: The receive accumulator `rx_crc` follows the same rule as R3 on `rx_word`, independently of the transmit side.
- R5: While the enable is low, `frame_done` leaves both accumulators unchanged.
- R6: Any change of `crc_on`, in either direction, clears both accumulators on the next cycle. This takes priority over a frame finishing in the same cycle.
- R7: A `next_req` pulse while enabled sets `next_pend`. The next finished frame is still accumulated as data, and `crc_slot` rises after it.
- R8: When a frame finishes while `crc_slot` is high, the block clears `next_pend` and `crc_slot` and leaves both accumulators unchanged. It sets `crc_err` if `rx_word` differs from `rx_crc`; in 8-bit mode only bits 7:0 are compared.
- R9: `crc_err` is sticky. A `stat_wr` cycle with `stat_wdata` bit 4 at 0 clears it. Bit 4 at 1 has no effect. A mismatch in the same cycle as a clear leaves the flag set.
- R10: `next_req` while the enable is low is ignored: `next_pend` stays low, also after re-enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_on | input | 1 | CRC calculation enable |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| poly_wr | input | 1 | Polynomial write strobe |
| poly_wdata | input | 16 | Polynomial write value |
| poly_q | output | 16 | Polynomial readback |
| next_req | input | 1 | One-shot request to send the check word after the next frame |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write value; bit 4 at 0 clears the error flag |
| frame_done | input | 1 | Frame finished strobe from the shift engine |
| tx_word | input | 16 | Word sent in the finished frame |
| rx_word | input | 16 | Word received in the finished frame |
| crc_slot | output | 1 | The current slot carries the check word |
| next_pend | output | 1 | Readback of the pending request |
| tx_crc | output | 16 | Transmit accumulator readback; the word sent in the check slot |
| rx_crc | output | 16 | Receive accumulator readback |
| crc_err | output | 1 | Sticky mismatch flag |

## Verification
A wrong accumulator bit shows on `tx_crc` or `rx_crc` one cycle after the frame that caused it, and it stays wrong for every later frame until the enable is toggled. Comparing against a bench model after every frame therefore localises the fault to a single word. A wrong sequencer state appears on `next_pend` or `crc_slot` one cycle after the request or the frame strobe. It also appears on `crc_err` one cycle after the check-slot frame, and there it persists until cleared. The checks cover both word widths, check words that match and check words that differ, and the corner cases where two events share a cycle.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARMED = 2'd2,
        ST_SEND  = 2'd3
    } crc_state_e;

    localparam int LANE_TX = 0;
    localparam int LANE_RX = 1;
    localparam int LANE_N  = 2;
endpackage

// File: rtl/frame_crc_fold.sv
module frame_crc_fold #(
    parameter int WORD_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [WORD_W-1:0] acc_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [WORD_W-1:0] poly_i,
    input  logic              wide_i,
    output logic [WORD_W-1:0] acc_o
);
    localparam int PAD_W = WORD_W - NARROW_W;

    logic [WORD_W-1:0]   wide_r;
    logic [NARROW_W-1:0] narrow_r;

    always_comb begin
        logic fb;
        wide_r = acc_i;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb     = wide_r[WORD_W-1] ^ data_i[i];
            wide_r = {wide_r[WORD_W-2:0], 1'b0} ^ (fb ? poly_i : '0);
        end
    end

    always_comb begin
        logic fb;
        narrow_r = acc_i[NARROW_W-1:0];
        for (int i = NARROW_W - 1; i >= 0; i--) begin
            fb       = narrow_r[NARROW_W-1] ^ data_i[i];
            narrow_r = {narrow_r[NARROW_W-2:0], 1'b0} ^ (fb ? poly_i[NARROW_W-1:0] : '0);
        end
    end

    assign acc_o = wide_i ? wide_r : {{PAD_W{1'b0}}, narrow_r};
endmodule

// File: rtl/frame_crc_lane.sv
module frame_crc_lane #(
    parameter int WORD_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic              wide_i,
    input  logic [WORD_W-1:0] poly_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] acc_o
);
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_nxt;

    frame_crc_fold #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_fold (
        .acc_i  (acc_q),
        .data_i (word_i),
        .poly_i (poly_i),
        .wide_i (wide_i),
        .acc_o  (acc_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr_i)  acc_q <= '0;
        else if (upd_i)  acc_q <= acc_nxt;
    end

    assign acc_o = acc_q;

    AST_LANE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_q == '0));                                   // R6
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !upd_i) |=> $stable(acc_q));                     // R5
endmodule

// File: rtl/frame_crc_seq.sv
module frame_crc_seq
    import frame_crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic crc_on_i,
    input  logic frame_done_i,
    input  logic next_req_i,
    output logic running_o,
    output logic acc_upd_o,
    output logic chk_now_o,
    output logic next_pend_o,
    output logic crc_slot_o
);
    crc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!crc_on_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_IDLE;
                ST_IDLE:  if (next_req_i)   state_d = ST_ARMED;
                ST_ARMED: if (frame_done_i) state_d = ST_SEND;
                ST_SEND:  if (frame_done_i) state_d = ST_IDLE;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        running_o   = 1'b1;
        acc_upd_o   = 1'b0;
        chk_now_o   = 1'b0;
        next_pend_o = 1'b0;
        crc_slot_o  = 1'b0;
        unique case (state_q)
            ST_OFF:   running_o = 1'b0;
            ST_IDLE:  acc_upd_o = frame_done_i && crc_on_i;
            ST_ARMED: begin
                acc_upd_o   = frame_done_i && crc_on_i;
                next_pend_o = 1'b1;
            end
            ST_SEND: begin
                chk_now_o   = frame_done_i && crc_on_i;
                next_pend_o = 1'b1;
                crc_slot_o  = 1'b1;
            end
            default:  running_o = 1'b0;
        endcase
    end

    AST_SLOT_AFTER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_slot_o) |-> $past(next_pend_o && frame_done_i));  // R7
    AST_SLOT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_slot_o && frame_done_i) |=> !crc_slot_o);              // R8
    AST_OFF_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !next_pend_o);                               // R10
endmodule

// File: rtl/frame_crc_engine.sv
module frame_crc_engine
    import frame_crc_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int NARROW_W   = 8,
    parameter int STAT_W     = 8,
    parameter int ERR_BIT    = 4,
    parameter int POLY_RESET = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_on,
    input  logic              wide_mode,
    input  logic              poly_wr,
    input  logic [WORD_W-1:0] poly_wdata,
    output logic [WORD_W-1:0] poly_q,
    input  logic              next_req,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              frame_done,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [WORD_W-1:0] rx_word,
    output logic              crc_slot,
    output logic              next_pend,
    output logic [WORD_W-1:0] tx_crc,
    output logic [WORD_W-1:0] rx_crc,
    output logic              crc_err
);
    localparam logic [WORD_W-1:0] POLY_INIT = WORD_W'(POLY_RESET);

    logic              running, acc_upd, chk_now, toggle;
    logic              mismatch, err_set, err_clr, err_q;
    logic [WORD_W-1:0] poly_r;
    logic [WORD_W-1:0] lane_word [LANE_N];
    logic [WORD_W-1:0] lane_acc  [LANE_N];

    frame_crc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .crc_on_i     (crc_on),
        .frame_done_i (frame_done),
        .next_req_i   (next_req),
        .running_o    (running),
        .acc_upd_o    (acc_upd),
        .chk_now_o    (chk_now),
        .next_pend_o  (next_pend),
        .crc_slot_o   (crc_slot)
    );

    assign toggle = crc_on ^ running;

    always_ff @(posedge clk) begin
        if (!rst_n)       poly_r <= POLY_INIT;
        else if (poly_wr) poly_r <= poly_wdata;
    end

    assign lane_word[LANE_TX] = tx_word;
    assign lane_word[LANE_RX] = rx_word;

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        frame_crc_lane #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (toggle),
            .upd_i  (acc_upd),
            .wide_i (wide_mode),
            .poly_i (poly_r),
            .word_i (lane_word[g]),
            .acc_o  (lane_acc[g])
        );
    end

    assign tx_crc = lane_acc[LANE_TX];
    assign rx_crc = lane_acc[LANE_RX];

    always_comb begin
        if (wide_mode) mismatch = (rx_word != lane_acc[LANE_RX]);
        else           mismatch = (rx_word[NARROW_W-1:0] != lane_acc[LANE_RX][NARROW_W-1:0]);
    end

    assign err_set = chk_now && mismatch;
    assign err_clr = stat_wr && !stat_wdata[ERR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    assign crc_err = err_q;
    assign poly_q  = poly_r;

    AST_POLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        poly_wr |=> (poly_q == $past(poly_wdata)));                 // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !err_clr) |=> crc_err);                         // R9
    AST_ERR_QUIET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_slot && frame_done && crc_on && !mismatch && !crc_err) |=> !crc_err); // R8
    AST_SLOT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_slot && frame_done && !toggle) |=> ($stable(tx_crc) && $stable(rx_crc))); // R8
endmodule

// File: tb/tb_frame_crc_engine.sv
`timescale 1ns/1ps
module tb_frame_crc_engine;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        crc_on = 0, wide_mode = 0, poly_wr = 0, next_req = 0;
    logic        stat_wr = 0, frame_done = 0;
    logic [15:0] poly_wdata = 0, tx_word = 0, rx_word = 0;
    logic [7:0]  stat_wdata = 0;
    logic [15:0] poly_q, tx_crc, rx_crc;
    logic        crc_slot, next_pend, crc_err;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] pol, m_tx, m_rx;

    always #2 clk = ~clk;

    frame_crc_engine dut (
        .clk(clk), .rst_n(rst_n), .crc_on(crc_on), .wide_mode(wide_mode),
        .poly_wr(poly_wr), .poly_wdata(poly_wdata), .poly_q(poly_q),
        .next_req(next_req), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .frame_done(frame_done), .tx_word(tx_word), .rx_word(rx_word),
        .crc_slot(crc_slot), .next_pend(next_pend), .tx_crc(tx_crc),
        .rx_crc(rx_crc), .crc_err(crc_err)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] a, input logic [15:0] d,
                                            input logic [15:0] p, input logic w);
        logic [7:0] a8;
        logic fb;
        if (w) begin
            for (int i = 15; i >= 0; i--) begin
                fb = a[15] ^ d[i];
                a  = {a[14:0], 1'b0} ^ (fb ? p : 16'h0);
            end
            return a;
        end
        a8 = a[7:0];
        for (int i = 7; i >= 0; i--) begin
            fb = a8[7] ^ d[i];
            a8 = {a8[6:0], 1'b0} ^ (fb ? p[7:0] : 8'h0);
        end
        return {8'h00, a8};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [15:0] t, input logic [15:0] r);
        @(negedge clk);
        frame_done = 1; tx_word = t; rx_word = r;
        @(negedge clk);
        frame_done = 0;
    endtask

    task automatic data_frame(input logic w);
        logic [15:0] t, r;
        t = 16'($urandom); r = 16'($urandom);
        frame(t, r);
        m_tx = ref_crc(m_tx, t, pol, w);
        m_rx = ref_crc(m_rx, r, pol, w);
    endtask

    task automatic pulse_next();
        @(negedge clk); next_req = 1;
        @(negedge clk); next_req = 0;
    endtask

    task automatic stat_write(input logic [7:0] v);
        @(negedge clk); stat_wr = 1; stat_wdata = v;
        @(negedge clk); stat_wr = 0;
    endtask

    task automatic set_on(input logic on);
        @(negedge clk); crc_on = on;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 poly", poly_q, 16'h0007);
        chk("R1 tx", tx_crc, 16'h0);
        chk("R1 rx", rx_crc, 16'h0);
        chk("R1 err", {15'h0, crc_err}, 16'h0);
        chk("R1 pend/slot", {14'h0, next_pend, crc_slot}, 16'h0);

        // R2 polynomial write
        pol = 16'h8005;
        @(negedge clk); poly_wr = 1; poly_wdata = pol;
        @(negedge clk); poly_wr = 0;
        chk("R2 poly", poly_q, pol);

        // R3 / R4 wide-mode accumulation, random words
        wide_mode = 1;
        set_on(1);
        m_tx = 0; m_rx = 0;
        for (int k = 0; k < 20; k++) begin
            data_frame(1'b1);
            chk("R3 tx wide", tx_crc, m_tx);
            chk("R4 rx wide", rx_crc, m_rx);
        end

        // R6 disable together with a frame: clear wins
        @(negedge clk); crc_on = 0; frame_done = 1; tx_word = 16'h1234; rx_word = 16'h5678;
        @(negedge clk); frame_done = 0;
        chk("R6 tx clear", tx_crc, 16'h0);
        chk("R6 rx clear", rx_crc, 16'h0);

        // R5 frames while disabled
        for (int k = 0; k < 3; k++) frame(16'($urandom), 16'hFFFF);
        chk("R5 tx held", tx_crc, 16'h0);
        chk("R5 rx held", rx_crc, 16'h0);

        // R3 / R4 narrow mode
        wide_mode = 0;
        set_on(1);
        m_tx = 0; m_rx = 0;
        for (int k = 0; k < 10; k++) begin
            data_frame(1'b0);
            chk("R3 tx narrow", tx_crc, m_tx);
            chk("R4 rx narrow", rx_crc, m_rx);
        end

        // R6 enable after accumulation clears; R10 request while off ignored
        set_on(0);
        pulse_next();
        chk("R10 pend off", {15'h0, next_pend}, 16'h0);
        set_on(1);
        m_tx = 0; m_rx = 0;
        chk("R10 pend after on", {15'h0, next_pend}, 16'h0);
        chk("R6 tx on-clear", tx_crc, 16'h0);

        // R7 / R8 narrow check slot, matching low byte, differing upper byte
        for (int k = 0; k < 3; k++) data_frame(1'b0);
        pulse_next();
        chk("R7 pend", {14'h0, next_pend, crc_slot}, 16'h2);
        data_frame(1'b0);
        chk("R7 slot", {15'h0, crc_slot}, 16'h1);
        chk("R7 last word tx", tx_crc, m_tx);
        frame(16'hDEAD, {8'hAB, m_rx[7:0]});
        chk("R8 match no err", {15'h0, crc_err}, 16'h0);
        chk("R8 slot cleared", {14'h0, next_pend, crc_slot}, 16'h0);
        chk("R8 tx frozen", tx_crc, m_tx);
        chk("R8 rx frozen", rx_crc, m_rx);

        // R8 mismatch, R9 sticky and clear behaviour
        data_frame(1'b0);
        pulse_next();
        data_frame(1'b0);
        frame(16'h0, m_rx ^ 16'h0001);
        chk("R8 mismatch err", {15'h0, crc_err}, 16'h1);
        data_frame(1'b0);
        chk("R9 sticky", {15'h0, crc_err}, 16'h1);
        stat_write(8'hFF);
        chk("R9 bit4 one no effect", {15'h0, crc_err}, 16'h1);
        stat_write(8'hEF);
        chk("R9 bit4 zero clears", {15'h0, crc_err}, 16'h0);
        chk("R9 tx untouched", tx_crc, m_tx);

        // R9 mismatch and clear in the same cycle: set wins
        pulse_next();
        data_frame(1'b0);
        @(negedge clk);
        frame_done = 1; tx_word = 0; rx_word = ~m_rx; stat_wr = 1; stat_wdata = 8'h00;
        @(negedge clk);
        frame_done = 0; stat_wr = 0;
        chk("R9 set wins", {15'h0, crc_err}, 16'h1);
        stat_write(8'h00);
        chk("R9 clear again", {15'h0, crc_err}, 16'h0);

        // R8 wide-mode slot, match then full-width mismatch
        set_on(0);
        wide_mode = 1;
        set_on(1);
        m_tx = 0; m_rx = 0;
        for (int k = 0; k < 4; k++) data_frame(1'b1);
        pulse_next();
        data_frame(1'b1);
        chk("R7 wide slot", {15'h0, crc_slot}, 16'h1);
        frame(16'h0, m_rx);
        chk("R8 wide match", {15'h0, crc_err}, 16'h0);
        pulse_next();
        data_frame(1'b1);
        frame(16'h0, m_rx ^ 16'h8000);
        chk("R8 wide upper mismatch", {15'h0, crc_err}, 16'h1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule